// File: doc/BRIEF.md
# Serial Register Access Port

This block is a slave port on a synchronous serial bus. Through it a host microprocessor reads and writes a bank of thirty-two 8-bit control registers. The host pulls chip select low, clocks in one command byte that carries a direction flag and a 5-bit register address, and then moves data bytes until it releases chip select. On a read the port shifts the addressed register out on a serial output. That output has an enable, and the pad driver outside the block uses it to tri-state the line.

The block runs on a fast system clock. The chip select, serial clock and serial data inputs pass through two-stage synchronizers and are then edge-detected. Input bits are taken on rising serial clock edges. Output bits change on falling serial clock edges. All registers are exported as a flat vector for the rest of the chip. Three bits of the register at address 0x10 also appear as dedicated controls: the digital interface mode select, the receive quiet enable and the transmit quiet enable.

The controller has four states:
- `ST_IDLE` waits for chip select to fall.
- `ST_CMD` gathers the command byte.
- `ST_RD` streams out the addressed register.
- `ST_WR` collects data bytes and writes them.

The transitions are:
- `ST_IDLE`→`ST_CMD` on a chip-select falling edge.
- `ST_CMD`→`ST_RD` or `ST_CMD`→`ST_WR` on the eighth rising clock edge, chosen by the direction flag.
- `ST_CMD`, `ST_RD` and `ST_WR` each return to `ST_IDLE` whenever chip select is seen high.

Top module: `sio_regport`

## Requirements
- R1: After reset all 32 registers read zero, `sdo_oe` is 0, and `if_mode`, `rx_quiet` and `tx_quiet` are 0.
- R2: The command byte is sent MSB first. Bit 7 = 1 means read and 0 means write. Bits 5..1 are the register address, with bit 5 as the address MSB. Bits 6 and 0 are ignored.
- R3: A data byte that is cut short by chip select rising before its eighth rising edge leaves the register unchanged.
- R4: On a write, each complete data byte is stored on its eighth rising serial clock edge. Every data byte in one selection goes to the same address, so the last complete byte wins.
- R5: On a read, the addressed register is sent MSB first. Each bit changes on a falling serial clock edge and is valid at the next rising edge. Every further byte in the same selection repeats the same register value.
- R6: `sdo_oe` is 0 while chip select is high, throughout the command byte, and throughout a write. It is 1 only during the data phase of a read.
- R7: Only the first byte after a chip-select falling edge is decoded as a command. A later byte whose value looks like a read command is stored as write data, and no read output starts.
- R8: `if_mode`, `rx_quiet` and `tx_quiet` follow bits 0, 1 and 2 of the register at address 0x10.
- R9: Driving `rst_n` low at any time, even in the middle of a transfer, clears every register and returns the port to idle.
- R10: A write data byte whose eighth rising serial clock edge arrives together with chip select rising is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from host, idles low |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Drive enable for the `sdo` pad; 0 means high impedance |
| reg_flat | output | 256 | All registers; register n is at bits [8n+7:8n] |
| if_mode | output | 1 | Digital interface mode select (reg 0x10 bit 0) |
| rx_quiet | output | 1 | Receive path quiet enable (reg 0x10 bit 1) |
| tx_quiet | output | 1 | Transmit path quiet enable (reg 0x10 bit 2) |

## Verification
Two events can land in the same system clock: completion of a write data byte, and the end of the selection. This happens when the host raises chip select at the same moment as the final rising serial clock edge. Both inputs pass through synchronizers of equal depth, so the byte-done strobe and the chip-select-high level reach the controller together. The bench provokes this by releasing chip select and raising the clock in the same instant. It then judges the outcome at the ports: the register must hold the new byte, and the port must come back idle so that a following read returns that byte through the scoreboard.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 8;
    localparam int SYNC_DEPTH = 2;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 5'h10;
    localparam int CTRL_MODE_BIT = 0;
    localparam int CTRL_RXQ_BIT  = 1;
    localparam int CTRL_TXQ_BIT  = 2;

    localparam int CMD_RW_BIT   = DATA_W - 1;
    localparam int CMD_ADDR_LSB = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } sio_state_t;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/sio_frame.sv
module sio_frame
    import sio_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          cs_n_s,
    input  logic          sdi_s,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          sdo,
    output logic          sdo_oe
);
    localparam int CNT_W = $clog2(DW);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);

    sio_state_t state, state_nx;
    logic              sclk_d, cs_d;
    logic              sclk_rise, sclk_fall, cs_fall, cs_hi;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DW-2:0]     in_sh;
    logic [DW-1:0]     full_byte, out_sh;
    logic [AW-1:0]     addr_q;
    logic              sdo_q, shifting, byte_done;

    // edge detection on synchronized inputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_n_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign cs_fall   = ~cs_n_s & cs_d;
    assign cs_hi     = cs_n_s;

    assign shifting  = (state == ST_CMD) || (state == ST_WR);
    assign full_byte = {in_sh, sdi_s};
    assign byte_done = shifting && sclk_rise && (bit_cnt == LAST_BIT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cs_fall) state_nx = ST_CMD;
            ST_CMD: begin
                if (cs_hi)          state_nx = ST_IDLE;
                else if (byte_done) state_nx = full_byte[CMD_RW_BIT] ? ST_RD : ST_WR;
            end
            ST_RD: if (cs_hi) state_nx = ST_IDLE;
            ST_WR: if (cs_hi) state_nx = ST_IDLE;
        endcase
    end

    // shifting datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            in_sh   <= '0;
            addr_q  <= '0;
            out_sh  <= '0;
            sdo_q   <= 1'b0;
        end else begin
            if (cs_hi) begin
                bit_cnt <= '0;
            end else if (shifting && sclk_rise) begin
                bit_cnt <= bit_cnt + 1'b1;
                in_sh   <= full_byte[DW-2:0];
            end
            if (state == ST_CMD && byte_done && !cs_hi) begin
                addr_q <= full_byte[CMD_ADDR_LSB +: AW];
                if (full_byte[CMD_RW_BIT]) out_sh <= rd_data;
            end
            if (state == ST_RD && sclk_fall) begin
                sdo_q  <= out_sh[DW-1];
                out_sh <= {out_sh[DW-2:0], out_sh[DW-1]};
            end
        end
    end

    // outputs
    always_comb begin
        rd_addr = (state == ST_CMD) ? full_byte[CMD_ADDR_LSB +: AW] : addr_q;
        wr_en   = (state == ST_WR) && byte_done;
        wr_addr = addr_q;
        wr_data = full_byte;
        sdo     = sdo_q;
        sdo_oe  = (state == ST_RD);
    end

    assert_idle_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !sdo_oe);
    assert_cnt_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> (bit_cnt == '0));
    assert_write_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR && !cs_hi) |=> (state == ST_WR));
    assert_read_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD && !cs_hi) |=> (state == ST_RD));
endmodule

// File: rtl/sio_regfile.sv
module sio_regfile
    import sio_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [DW-1:0]           rd_data,
    output logic [(DW<<AW)-1:0]     flat,
    output logic                    if_mode,
    output logic                    rx_quiet,
    output logic                    tx_quiet
);
    localparam int NREGS = 1 << AW;

    logic [DW-1:0] mem [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    for (genvar g = 0; g < NREGS; g++) begin : g_flat
        assign flat[g*DW +: DW] = mem[g];
    end

    assign if_mode  = mem[CTRL_ADDR][CTRL_MODE_BIT];
    assign rx_quiet = mem[CTRL_ADDR][CTRL_RXQ_BIT];
    assign tx_quiet = mem[CTRL_ADDR][CTRL_TXQ_BIT];

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));
    assert_ctrl_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CTRL_ADDR) |=>
            (if_mode == $past(wr_data[CTRL_MODE_BIT]) && tx_quiet == $past(wr_data[CTRL_TXQ_BIT])));
endmodule

// File: rtl/sio_regport.sv
module sio_regport
    import sio_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                sdi,
    output logic                sdo,
    output logic                sdo_oe,
    output logic [(DW<<AW)-1:0] reg_flat,
    output logic                if_mode,
    output logic                rx_quiet,
    output logic                tx_quiet
);
    logic [2:0]    pins_s;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, wr_data;
    logic          wr_en;

    // bit 0 serial clock, bit 1 chip select, bit 2 data in
    sio_sync #(.W(3), .STAGES(SYNC_DEPTH), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({sdi, cs_n, sclk}),
        .q_out (pins_s)
    );

    sio_frame #(.AW(AW), .DW(DW)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (pins_s[0]),
        .cs_n_s  (pins_s[1]),
        .sdi_s   (pins_s[2]),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe)
    );

    sio_regfile #(.AW(AW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .flat     (reg_flat),
        .if_mode  (if_mode),
        .rx_quiet (rx_quiet),
        .tx_quiet (tx_quiet)
    );
endmodule

// File: tb/sim_sio_regport.sv
`timescale 1ns/1ps
module sim_sio_regport;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo, sdo_oe, if_mode, rx_quiet, tx_quiet;
    logic [255:0] reg_flat;

    int checks = 0;
    int fails = 0;
    bit wr_phase = 1'b0;
    logic [7:0] exp_q [$];

    always #10 clk = ~clk;

    sio_regport u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .reg_flat(reg_flat),
        .if_mode(if_mode), .rx_quiet(rx_quiet), .tx_quiet(tx_quiet)
    );

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sdi = b[i];
            waitc(H);
            sclk = 1'b1;
            waitc(H);
            sclk = 1'b0;
        end
    endtask

    task automatic sel;
        cs_n = 1'b0;
        waitc(H);
    endtask

    task automatic desel;
        waitc(H);
        cs_n = 1'b1;
        waitc(3 * H);
    endtask

    task automatic wr_txn(input logic [4:0] a, input logic [7:0] d0, input logic [7:0] d1, input int nb, input logic [7:0] junk);
        wr_phase = 1'b1;
        sel();
        send_bits({1'b0, junk[6], a, junk[0]}, 8);
        send_bits(d0, 8);
        if (nb > 1) send_bits(d1, 8);
        desel();
        wr_phase = 1'b0;
    endtask

    task automatic rd_txn(input logic [4:0] a, input int nb, input logic [7:0] expv);
        for (int k = 0; k < nb; k++) exp_q.push_back(expv);
        sel();
        send_bits({1'b1, 1'b0, a, 1'b0}, 8);
        for (int k = 0; k < nb; k++) send_bits(8'h00, 8);
        desel();
    endtask

    function automatic logic [7:0] regv(input int a);
        return reg_flat[a*8 +: 8];
    endfunction

    // monitor / scoreboard
    int rc = 0;
    logic [7:0] got = '0;
    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            rc = 0;
        end else begin
            if (rc < 8 || wr_phase) begin
                chk(sdo_oe == 1'b0, "R6 oe during command/write", 256'(sdo_oe), 0);
            end else begin
                chk(sdo_oe == 1'b1, "R5 oe in read data", 256'(sdo_oe), 1);
                got = {got[6:0], sdo};
                if (rc % 8 == 7) begin
                    if (exp_q.size() == 0) chk(1'b0, "R5 unexpected read byte", 256'(got), 0);
                    else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(got == e, "R5 read byte", 256'(got), 256'(e));
                    end
                end
            end
            rc++;
        end
    end

    initial begin
        waitc(150000);
        chk(1'b0, "watchdog", 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        waitc(5);
        rst_n = 1'b1;
        waitc(5);
        // R1
        chk(reg_flat == '0, "R1 regs zero", reg_flat, 0);
        chk(sdo_oe == 1'b0, "R1 oe low", 256'(sdo_oe), 0);
        chk({if_mode, rx_quiet, tx_quiet} == 3'b000, "R1 ctrl low", 256'({if_mode, rx_quiet, tx_quiet}), 0);

        // R2 write/read, ignored command bits set
        wr_txn(5'h05, 8'hA5, 8'h00, 1, 8'h41);
        chk(regv(5) == 8'hA5, "R2 write reg05", 256'(regv(5)), 256'(8'hA5));
        rd_txn(5'h05, 1, 8'hA5);
        wr_txn(5'h1F, 8'h3C, 8'h00, 1, 8'h00);
        wr_txn(5'h00, 8'hC3, 8'h00, 1, 8'h01);
        chk(regv(31) == 8'h3C, "R2 addr MSB reg1F", 256'(regv(31)), 256'(8'h3C));
        chk(regv(0) == 8'hC3, "R2 addr zero", 256'(regv(0)), 256'(8'hC3));
        // R5 repeated bytes
        rd_txn(5'h1F, 3, 8'h3C);
        rd_txn(5'h00, 1, 8'hC3);
        chk(sdo_oe == 1'b0, "R6 oe after read", 256'(sdo_oe), 0);

        // R4 multi-byte write
        wr_txn(5'h07, 8'h11, 8'h22, 2, 8'h00);
        chk(regv(7) == 8'h22, "R4 last byte wins", 256'(regv(7)), 256'(8'h22));

        // R3 partial byte discarded
        wr_phase = 1'b1;
        sel();
        send_bits(8'h10, 8);
        send_bits(8'h5A, 8);
        send_bits(8'hFF, 4);
        desel();
        wr_phase = 1'b0;
        chk(regv(8) == 8'h5A, "R3 partial discarded", 256'(regv(8)), 256'(8'h5A));

        // R7 read-looking data byte stays data
        wr_txn(5'h09, 8'h82, 8'h44, 2, 8'h00);
        chk(regv(9) == 8'h44, "R7 data not command", 256'(regv(9)), 256'(8'h44));
        chk(regv(1) == 8'h00, "R7 no other reg touched", 256'(regv(1)), 0);

        // R8 control outputs
        wr_txn(5'h10, 8'h07, 8'h00, 1, 8'h00);
        chk({if_mode, rx_quiet, tx_quiet} == 3'b111, "R8 ctrl all set", 256'({if_mode, rx_quiet, tx_quiet}), 7);
        wr_txn(5'h10, 8'h02, 8'h00, 1, 8'h00);
        chk({if_mode, rx_quiet, tx_quiet} == 3'b010, "R8 rx only", 256'({if_mode, rx_quiet, tx_quiet}), 2);

        // R10 byte done coincident with deselect
        wr_phase = 1'b1;
        sel();
        send_bits(8'h14, 8);
        send_bits(8'h99, 7);
        sdi = 1'b1;
        waitc(H);
        sclk = 1'b1;
        cs_n = 1'b1;
        waitc(H);
        sclk = 1'b0;
        waitc(3 * H);
        wr_phase = 1'b0;
        chk(regv(10) == 8'h99, "R10 coincident write", 256'(regv(10)), 256'(8'h99));
        rd_txn(5'h0A, 1, 8'h99);

        // R9 async reset mid-transfer
        wr_phase = 1'b1;
        sel();
        send_bits(8'h16, 8);
        send_bits(8'hEE, 3);
        #3;
        rst_n = 1'b0;
        cs_n = 1'b1;
        sdi = 1'b0;
        #4;
        chk(reg_flat == '0, "R9 regs cleared", reg_flat, 0);
        waitc(3);
        rst_n = 1'b1;
        wr_phase = 1'b0;
        waitc(3 * H);
        chk(sdo_oe == 1'b0, "R9 idle after reset", 256'(sdo_oe), 0);
        rd_txn(5'h05, 1, 8'h00);
        chk(regv(11) == 8'h00, "R9 aborted write absent", 256'(regv(11)), 0);

        waitc(4 * H);
        chk(exp_q.size() == 0, "R5 all reads seen", 256'(exp_q.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule